// File: doc/BRIEF.md
# Four-Port Address-Routed Packet Switch

This block takes byte-wide packets from a single input and forwards each whole packet to one of four output ports. The first byte of every packet is a destination address; the block compares it with four port addresses that software writes into a small store through a write-only memory-style interface. The packet is steered to the port whose address matches. Packets without a match, or that arrive when the chosen port cannot be sure of holding them, are swallowed whole.

A packet is framed by holding the status input high for its bytes: destination, source, payload length, the payload, and a closing byte that is the XOR of all earlier bytes. The switch does not interpret the source, length or check bytes; it stores them with the rest. Each output port owns a FIFO and signals with `ready` that a complete packet is waiting. The consumer raises `read` and receives one byte per clock, starting one clock later.

Top module: `pkt_switch4`

## Requirements
- R1: A store entry is written on a rising edge only when `mem_en` and `mem_rd_wr` are both high, with `mem_add` choosing the entry (entry n is the address of port n) and `mem_data` the value; with either strobe low the entry keeps its value.
- R2: While reset is high and after its release, every `ready` bit is low, every port data output is 0x00 and every store entry is 0x00.
- R3: A packet is written only to the port whose stored address equals its first byte.
- R4: The port delivers every byte of the packet, unmodified and in input order, including the source, length and check bytes, for length+4 bytes in total.
- R5: `ready` of the target port, if it held no packet before, is still low at the clock after the last byte was sampled and is high after the following rising edge.
- R6: A byte appears on the port data output after the rising edge that samples `read` high, one byte per edge; with no complete packet buffered, `read` is ignored and the data output holds its value.
- R7: A packet whose first byte matches no entry is dropped completely: no port raises `ready` and later packets are unaffected.
- R8: A packet is dropped if, at its first byte, its target FIFO has fewer free entries than a maximum packet (259 bytes); a FIFO never overflows.
- R9: When several entries hold the same address, the lowest-numbered port receives the packet.
- R10: Packets with payload length 0 (4 bytes) and 255 (259 bytes) are forwarded whole.
- R11: Several packets queue in one port in arrival order; `ready` stays high until the last byte of the last buffered packet has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| mem_en | input | 1 | Configuration strobe |
| mem_rd_wr | input | 1 | Configuration write select (high = write) |
| mem_add | input | 2 | Store entry (port number) to write |
| mem_data | input | 8 | Port address to store |
| data_status | input | 1 | High for every byte of an incoming packet |
| data | input | 8 | Incoming packet byte |
| port_data | output | 4x8 | Per-port output byte, index n is port n |
| ready | output | 4 | Per-port: a complete packet is buffered |
| read | input | 4 | Per-port: consumer takes one byte per clock |

## Verification
A store write takes effect at the edge it is sampled and governs any packet whose first byte arrives afterwards. A packet's last byte is registered at its sampling edge and committed at the next one, so `ready` is checked low one cycle after the last byte and high one cycle later. Each read byte is compared at the falling edge after the rising edge that took `read`, and `read` is dropped before the edge following the final byte so exactly one packet leaves. Drop cases are judged by `ready` and by the contents of the next packet read from the same port.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int BYTE_W      = 8;
  localparam int HDR_BYTES   = 3;
  localparam int MAX_PAYLOAD = 255;
  localparam int MAX_PKT     = HDR_BYTES + MAX_PAYLOAD + 1;

  // Total bytes of a packet carrying the given payload length.
  function automatic int unsigned pkt_bytes(input logic [BYTE_W-1:0] len);
    return int'(len) + HDR_BYTES + 1;
  endfunction

  // A FIFO may accept a new packet only if a worst-case packet fits.
  function automatic logic fits_worst(input int unsigned free_entries);
    return free_entries >= MAX_PKT;
  endfunction
endpackage

// File: rtl/psw_addr_table.sv
module psw_addr_table #(
  parameter int NPORTS = 4,
  parameter int AW     = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               we,
  input  logic [AW-1:0]                      waddr,
  input  logic [psw_pkg::BYTE_W-1:0]         wdata,
  output logic [NPORTS-1:0][psw_pkg::BYTE_W-1:0] addrs
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) addrs <= '0;
    else if (we) addrs[waddr] <= wdata;
  end
endmodule

// File: rtl/psw_ingress.sv
module psw_ingress #(
  parameter int NPORTS = 4,
  parameter int PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   in_valid,
  input  logic [psw_pkg::BYTE_W-1:0]             in_byte,
  input  logic [NPORTS-1:0][psw_pkg::BYTE_W-1:0] addrs,
  input  logic [NPORTS-1:0]                      room_ok,
  output logic [NPORTS-1:0]                      wr_vec,
  output logic [psw_pkg::BYTE_W-1:0]             wr_byte,
  output logic                                   wr_last,
  output logic                                   sop,
  output logic                                   pkt_drop
);
  logic          in_pkt_q, keep_q, pend_v;
  logic [PW-1:0] port_q, pend_p, hit_idx, cur_port;
  logic [psw_pkg::BYTE_W-1:0] pend_d;
  logic          hit_any, keep_new, keep_now;

  // Lookup: scan downwards so the lowest matching index wins.
  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = NPORTS - 1; i >= 0; i--) begin
      if (addrs[i] == in_byte) begin
        hit_any = 1'b1;
        hit_idx = PW'(i);
      end
    end
  end

  assign sop      = in_valid & ~in_pkt_q;
  assign keep_new = hit_any & room_ok[hit_idx];
  assign keep_now = sop ? keep_new : keep_q;
  assign cur_port = sop ? hit_idx : port_q;
  assign pkt_drop = sop & ~keep_new;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      in_pkt_q <= 1'b0;
      keep_q   <= 1'b0;
      port_q   <= '0;
      pend_v   <= 1'b0;
      pend_d   <= '0;
      pend_p   <= '0;
    end else begin
      in_pkt_q <= in_valid;
      if (sop) begin
        keep_q <= keep_new;
        port_q <= hit_idx;
      end
      pend_v <= in_valid & keep_now;
      pend_d <= in_byte;
      pend_p <= cur_port;
    end
  end

  // The held byte is the last one when the frame has just closed.
  assign wr_byte = pend_d;
  assign wr_last = ~in_valid;
  always_comb begin
    for (int i = 0; i < NPORTS; i++) wr_vec[i] = pend_v && (pend_p == PW'(i));
  end
endmodule

// File: rtl/psw_port_fifo.sv
module psw_port_fifo #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [psw_pkg::BYTE_W-1:0] push_byte,
  input  logic                       push_last,
  input  logic                       rd,
  output logic [psw_pkg::BYTE_W-1:0] dout,
  output logic                       ready,
  output logic                       room_ok,
  output logic                       pop,
  output logic                       full
);
  logic [psw_pkg::BYTE_W:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt, pkt_cnt;
  logic          head_last, pkt_in, pkt_out;

  assign ready     = (pkt_cnt != '0);
  assign pop       = rd & ready;
  assign full      = (cnt == CW'(DEPTH));
  assign room_ok   = psw_pkg::fits_worst(int'(CW'(DEPTH) - cnt));
  assign head_last = mem[rd_ptr][psw_pkg::BYTE_W];
  assign pkt_in    = push & push_last;
  assign pkt_out   = pop & head_last;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {push_last, push_byte};
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      pkt_cnt <= '0;
      dout    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop) begin
        rd_ptr <= rd_ptr + 1'b1;
        dout   <= mem[rd_ptr][psw_pkg::BYTE_W-1:0];
      end
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      case ({pkt_in, pkt_out})
        2'b10:   pkt_cnt <= pkt_cnt + 1'b1;
        2'b01:   pkt_cnt <= pkt_cnt - 1'b1;
        default: pkt_cnt <= pkt_cnt;
      endcase
    end
  end
endmodule

// File: rtl/pkt_switch4.sv
module pkt_switch4 #(
  parameter int NPORTS     = 4,
  parameter int FIFO_DEPTH = 512,
  parameter int AW         = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   mem_en,
  input  logic                                   mem_rd_wr,
  input  logic [AW-1:0]                          mem_add,
  input  logic [psw_pkg::BYTE_W-1:0]             mem_data,
  input  logic                                   data_status,
  input  logic [psw_pkg::BYTE_W-1:0]             data,
  output logic [NPORTS-1:0][psw_pkg::BYTE_W-1:0] port_data,
  output logic [NPORTS-1:0]                      ready,
  input  logic [NPORTS-1:0]                      read
);
  logic [NPORTS-1:0][psw_pkg::BYTE_W-1:0] addrs;
  logic [NPORTS-1:0] room_vec, wr_vec, pop_vec, full_vec;
  logic [psw_pkg::BYTE_W-1:0] wr_byte;
  logic wr_last, sop, pkt_drop, cfg_we;

  assign cfg_we = mem_en & mem_rd_wr;

  psw_addr_table #(.NPORTS(NPORTS), .AW(AW)) u_table (
    .clk(clk), .rst(rst), .we(cfg_we), .waddr(mem_add), .wdata(mem_data),
    .addrs(addrs)
  );

  psw_ingress #(.NPORTS(NPORTS), .PW(AW)) u_ingress (
    .clk(clk), .rst(rst), .in_valid(data_status), .in_byte(data),
    .addrs(addrs), .room_ok(room_vec), .wr_vec(wr_vec), .wr_byte(wr_byte),
    .wr_last(wr_last), .sop(sop), .pkt_drop(pkt_drop)
  );

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    psw_port_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .push(wr_vec[g]), .push_byte(wr_byte),
      .push_last(wr_last), .rd(read[g]), .dout(port_data[g]),
      .ready(ready[g]), .room_ok(room_vec[g]), .pop(pop_vec[g]),
      .full(full_vec[g])
    );
  end
endmodule

// File: rtl/psw_checks.sv
module psw_checks #(
  parameter int NPORTS = 4
) (
  input logic                                   clk,
  input logic                                   rst,
  input logic                                   data_status,
  input logic [NPORTS-1:0][psw_pkg::BYTE_W-1:0] port_data,
  input logic [NPORTS-1:0]                      ready,
  input logic [NPORTS-1:0]                      read,
  input logic [NPORTS-1:0]                      wr_vec,
  input logic [NPORTS-1:0]                      full_vec,
  input logic                                   pkt_drop
);
  p_reset_quiet_r2: assert property (@(posedge clk) rst |-> (ready == '0));

  p_single_target_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_vec));

  p_write_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_vec != '0) |-> $past(data_status));

  p_drop_silent_r7: assert property (@(posedge clk) disable iff (rst)
    pkt_drop |=> (wr_vec == '0));

  for (genvar g = 0; g < NPORTS; g++) begin : g_chk
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
      wr_vec[g] |-> !full_vec[g]);

    p_idle_read_r6: assert property (@(posedge clk) disable iff (rst)
      (read[g] && !ready[g]) |=> $stable(port_data[g]));
  end
endmodule

bind pkt_switch4 psw_checks #(.NPORTS(NPORTS)) u_chk (.*);

// File: tb/sim_pkt_switch4.sv
module sim_pkt_switch4;
  localparam int NP = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, mem_en, mem_rd_wr, data_status;
  logic [1:0] mem_add;
  logic [7:0] mem_data, data;
  logic [NP-1:0][7:0] port_data;
  logic [NP-1:0] ready, read;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] exp_b [0:258];
  int exp_n;
  logic [NP-1:0] r_before;
  logic [7:0] paddr [NP] = '{8'h10, 8'h21, 8'h32, 8'h43};

  pkt_switch4 u0 (
    .clk(clk), .rst(rst), .mem_en(mem_en), .mem_rd_wr(mem_rd_wr),
    .mem_add(mem_add), .mem_data(mem_data), .data_status(data_status),
    .data(data), .port_data(port_data), .ready(ready), .read(read)
  );

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int idx, input logic [7:0] val, input bit en, input bit rw);
    mem_en = en; mem_rd_wr = rw; mem_add = 2'(idx); mem_data = val;
    @(negedge clk);
    mem_en = 1'b0; mem_rd_wr = 1'b0; mem_add = '0; mem_data = '0;
  endtask

  task automatic mk_pkt(input logic [7:0] da, input logic [7:0] sa,
                        input int len, input logic [7:0] seed);
    logic [7:0] x;
    exp_b[0] = da; exp_b[1] = sa; exp_b[2] = 8'(len);
    for (int i = 0; i < len; i++) exp_b[3 + i] = 8'(seed + 8'(i * 13));
    x = 8'h00;
    for (int i = 0; i < len + 3; i++) x = x ^ exp_b[i];
    exp_b[3 + len] = x;
    exp_n = len + 4;
  endtask

  // Drives the current packet; returns one edge after the frame closed.
  task automatic send();
    for (int i = 0; i < exp_n; i++) begin
      data_status = 1'b1; data = exp_b[i];
      @(negedge clk);
    end
    data_status = 1'b0; data = '0;
    r_before = ready;
    @(negedge clk);
  endtask

  task automatic recv(input int p, input string req);
    read[p] = 1'b1;
    for (int i = 0; i < exp_n; i++) begin
      @(negedge clk);
      check(req, port_data[p], exp_b[i]);
    end
    read[p] = 1'b0;
  endtask

  task automatic t_reset();
    check("R2 ready after reset", ready, 0);
    for (int p = 0; p < NP; p++) check("R2 port data after reset", port_data[p], 0);
    // Entries reset to 0x00: a packet to address 0x00 lands on port 0.
    mk_pkt(8'h00, 8'h01, 1, 8'h40);
    send();
    check("R2 zero entries route to port 0", ready, 4'b0001);
    recv(0, "R2 data");
    cyc(3);
  endtask

  task automatic t_route();
    for (int p = 0; p < NP; p++) cfg(p, paddr[p], 1'b1, 1'b1);
    for (int p = 0; p < NP; p++) begin
      mk_pkt(paddr[p], 8'h5A, 8 + p * 3, 8'(p));
      send();
      check("R5 ready low right after last byte", r_before, 0);
      check("R3 R5 only target port ready", ready, 1 << p);
      recv(p, "R4 byte");
      check("R11 ready low after drain", ready, 0);
      cyc(3);
    end
  endtask

  task automatic t_read_idle();
    logic [NP-1:0][7:0] held;
    held = port_data;
    read = '1;
    cyc(3);
    read = '0;
    for (int p = 0; p < NP; p++) check("R6 read ignored when empty", port_data[p], held[p]);
    check("R6 ready stays low", ready, 0);
  endtask

  task automatic t_ignored_write();
    cfg(0, 8'h99, 1'b1, 1'b0);
    cfg(0, 8'h99, 1'b0, 1'b1);
    mk_pkt(8'h99, 8'h02, 3, 8'h11);
    send();
    check("R1 write without both strobes ignored", ready, 0);
    cyc(3);
    mk_pkt(paddr[0], 8'h02, 3, 8'h12);
    send();
    check("R1 entry 0 kept old address", ready, 4'b0001);
    recv(0, "R1 data");
    cyc(3);
  endtask

  task automatic t_unmatched();
    mk_pkt(8'hEE, 8'h03, 6, 8'h20);
    send();
    check("R7 unmatched packet dropped", ready, 0);
    cyc(3);
    mk_pkt(paddr[2], 8'h03, 4, 8'h21);
    send();
    check("R7 next packet routed", ready, 4'b0100);
    recv(2, "R7 next packet intact");
    cyc(3);
  endtask

  task automatic t_lengths();
    mk_pkt(paddr[3], 8'h04, 0, 8'h00);
    send();
    check("R10 empty payload ready", ready, 4'b1000);
    recv(3, "R10 four-byte packet");
    check("R10 ready clears after 4 bytes", ready, 0);
    cyc(3);
    mk_pkt(paddr[3], 8'h04, 255, 8'h33);
    send();
    check("R10 max payload ready", ready, 4'b1000);
    recv(3, "R10 259-byte packet");
    check("R10 ready clears after 259 bytes", ready, 0);
    cyc(3);
  endtask

  task automatic t_queue();
    mk_pkt(paddr[2], 8'h05, 5, 8'h07);
    send();
    cyc(3);
    mk_pkt(paddr[2], 8'h06, 9, 8'h08);
    send();
    check("R11 two packets queued", ready, 4'b0100);
    mk_pkt(paddr[2], 8'h05, 5, 8'h07);
    recv(2, "R11 first packet first");
    check("R11 ready held for second", ready, 4'b0100);
    mk_pkt(paddr[2], 8'h06, 9, 8'h08);
    recv(2, "R11 second packet");
    check("R11 ready low when empty", ready, 0);
    cyc(3);
  endtask

  task automatic t_full();
    mk_pkt(paddr[1], 8'h07, 255, 8'h50);
    send();
    cyc(3);
    mk_pkt(paddr[1], 8'h07, 1, 8'h60);
    send();
    check("R8 port 1 holds one packet", ready, 4'b0010);
    cyc(3);
    mk_pkt(paddr[0], 8'h07, 3, 8'h70);
    send();
    check("R8 other port unaffected", ready, 4'b0011);
    recv(0, "R8 other port data");
    mk_pkt(paddr[1], 8'h07, 255, 8'h50);
    recv(1, "R8 big packet intact");
    check("R8 packet without room dropped", ready, 0);
    cyc(3);
    mk_pkt(paddr[1], 8'h08, 1, 8'h61);
    send();
    check("R8 room back after drain", ready, 4'b0010);
    recv(1, "R8 after drain");
    cyc(3);
  endtask

  task automatic t_dup();
    cfg(3, paddr[1], 1'b1, 1'b1);
    mk_pkt(paddr[1], 8'h09, 2, 8'h80);
    send();
    check("R9 lowest port wins", ready, 4'b0010);
    recv(1, "R9 data");
    cyc(3);
    cfg(3, paddr[3], 1'b1, 1'b1);
    cfg(2, 8'h77, 1'b1, 1'b1);
    mk_pkt(8'h77, 8'h09, 2, 8'h81);
    send();
    check("R1 reprogrammed entry used", ready, 4'b0100);
    recv(2, "R1 data after reprogram");
    cyc(3);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    rst = 1'b1; mem_en = 1'b0; mem_rd_wr = 1'b0; mem_add = '0; mem_data = '0;
    data_status = 1'b0; data = '0; read = '0;
    cyc(4);
    check("R2 ready during reset", ready, 0);
    rst = 1'b0;
    cyc(2);
    t_reset();
    t_route();
    t_read_idle();
    t_ignored_write();
    t_unmatched();
    t_lengths();
    t_queue();
    t_full();
    t_dup();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule